// File: doc/BRIEF.md
# Wrap-Around Mesh Route Fabric

The block is a two-dimensional grid of ROWS by COLS processing elements driven in lock-step by one broadcast command. Every element owns three data registers: an accumulator A, a routing register R and a spare register T. A single step command either moves R values one place across the grid, sorts the A/R pair of each element, or swaps that pair. A per-element activation mask selects which elements obey the command.

Elements are numbered in row-major order, so element (row, col) has index row*COLS+col. Vertical links wrap modulo the row count. Horizontal links do not wrap inside a row. Moving right from the last column lands on column 0 of the next row, and moving left from column 0 lands on the last column of the previous row. The horizontal direction therefore behaves as one ring through all elements in index order. A load port writes any single register, and a combinational read port returns any single register. Together they give the surrounding controller access to the array state.

Top module: `mesh_route_fabric`

## Requirements
- R1: After reset is asserted (rst_n low), every A, R and T register of every element reads zero.
- R2: With ld_en high, ld_data is written at the clock edge into element ld_idx (row-major index), register selected by ld_sel (0=A, 1=R, 2=T, 3=none). rd_data shows the register picked by rd_idx and rd_sel with the same encoding, combinationally, and shows zero for selector 3.
- R3: A route (step_op 0) with route_dir 1 (right) sets each active element's R to the R of element (index+1) mod ROWS*COLS. This is the next column, or column 0 of the next row from the last column, and element 0 from the last element.
- R4: A route with route_dir 0 (left) sets each active element's R to the R of element (index-1) mod ROWS*COLS. This is the previous column, or the last column of the previous row from column 0.
- R5: A route with route_dir 2 (up) copies R from row (row-1) mod ROWS, same column. route_dir 3 (down) copies R from row (row+1) mod ROWS, same column.
- R6: A route completes in one clock edge, and every element uses the R values held before that edge.
- R7: An element whose act_mask bit is 0 keeps A, R and T unchanged during a step, yet still supplies its R to routing neighbours.
- R8: Compare-exchange (step_op 1) leaves min(A,R) in R and max(A,R) in A in every active element, treating both as unsigned numbers.
- R9: Exchange (step_op 2) swaps A and R in every active element. step_op 3 changes nothing.
- R10: No step operation changes T. A route changes only R.
- R11: When a load and a step hit the same element in one cycle, the loaded register takes ld_data. The element's other registers take their step result.
- R12: With step_en low and no load, no register changes, whatever step_op, route_dir and act_mask carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Apply the broadcast step this cycle |
| step_op | input | 2 | 0 route, 1 compare-exchange, 2 exchange, 3 idle |
| route_dir | input | 2 | 0 left, 1 right, 2 up, 3 down |
| act_mask | input | ROWS*COLS | Per-element activation, bit k for element k |
| ld_en | input | 1 | Load strobe |
| ld_idx | input | clog2(ROWS*COLS) | Element index for load |
| ld_sel | input | 2 | Register select for load |
| ld_data | input | W | Load value |
| rd_idx | input | clog2(ROWS*COLS) | Element index for read |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | W | Read value |

## Verification
A register load and a broadcast step can land in the same clock edge on the same element. In that case the loaded register must take the load value, and the element's other registers must still take the step result. The bench provokes this with directed cases that load R during a route and A during a compare-exchange. It also overlaps random loads with random steps across a 4 by 8 grid. After each edge it reads every register of every element through the read port and compares it with a bench model. That model resolves the horizontal wrap from row and column arithmetic rather than from the linear index.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    typedef enum logic [1:0] {
        OP_ROUTE = 2'd0,
        OP_CMPX  = 2'd1,
        OP_SWAP  = 2'd2,
        OP_IDLE  = 2'd3
    } step_op_e;

    typedef enum logic [1:0] {
        DIR_LEFT  = 2'd0,
        DIR_RIGHT = 2'd1,
        DIR_UP    = 2'd2,
        DIR_DOWN  = 2'd3
    } route_dir_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_R    = 2'd1,
        SEL_T    = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/mesh_link_mux.sv
module mesh_link_mux
    import mesh_pkg::*;
#(
    parameter int W = 8
) (
    input  route_dir_e     dir,
    input  logic [W-1:0]   from_left,
    input  logic [W-1:0]   from_right,
    input  logic [W-1:0]   from_up,
    input  logic [W-1:0]   from_down,
    output logic [W-1:0]   nbr_r
);

    always_comb begin
        unique case (dir)
            DIR_LEFT:  nbr_r = from_left;
            DIR_RIGHT: nbr_r = from_right;
            DIR_UP:    nbr_r = from_up;
            DIR_DOWN:  nbr_r = from_down;
        endcase
    end

endmodule

// File: rtl/mesh_pe.sv
module mesh_pe
    import mesh_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  step_op_e       op,
    input  logic           active,
    input  logic [W-1:0]   nbr_r,
    input  logic           ld_a,
    input  logic           ld_r,
    input  logic           ld_t,
    input  logic [W-1:0]   ld_data,
    output logic [W-1:0]   a_q,
    output logic [W-1:0]   r_q,
    output logic [W-1:0]   t_q
);

    logic [W-1:0] a_d, r_d, t_d;

    always_comb begin
        a_d = a_q;
        r_d = r_q;
        t_d = t_q;
        if (step_en && active) begin
            unique case (op)
                OP_ROUTE: r_d = nbr_r;
                OP_CMPX: begin
                    if (a_q < r_q) begin
                        r_d = a_q;
                        a_d = r_q;
                    end
                end
                OP_SWAP: begin
                    r_d = a_q;
                    a_d = r_q;
                end
                OP_IDLE: ;
            endcase
        end
        if (ld_a) a_d = ld_data;
        if (ld_r) r_d = ld_data;
        if (ld_t) t_d = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            r_q <= '0;
            t_q <= '0;
        end else begin
            a_q <= a_d;
            r_q <= r_d;
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/mesh_route_fabric.sv
module mesh_route_fabric
    import mesh_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  step_en,
    input  logic [1:0]                            step_op,
    input  logic [1:0]                            route_dir,
    input  logic [ROWS*COLS-1:0]                  act_mask,
    input  logic                                  ld_en,
    input  logic [$clog2(ROWS*COLS)-1:0]          ld_idx,
    input  logic [1:0]                            ld_sel,
    input  logic [W-1:0]                          ld_data,
    input  logic [$clog2(ROWS*COLS)-1:0]          rd_idx,
    input  logic [1:0]                            rd_sel,
    output logic [W-1:0]                          rd_data
);

    localparam int N    = ROWS * COLS;
    localparam int IDXW = $clog2(N);

    logic [N*W-1:0] a_all, r_all, t_all;

    step_op_e   op_e;
    route_dir_e dir_e;
    reg_sel_e   ld_sel_e, rd_sel_e;

    assign op_e     = step_op_e'(step_op);
    assign dir_e    = route_dir_e'(route_dir);
    assign ld_sel_e = reg_sel_e'(ld_sel);
    assign rd_sel_e = reg_sel_e'(rd_sel);

    for (genvar k = 0; k < N; k++) begin : g_pe
        // Row-major ring for horizontal moves, column ring for vertical
        localparam int LI = (k + N - 1) % N;
        localparam int RI = (k + 1) % N;
        localparam int UI = (k + N - COLS) % N;
        localparam int DI = (k + COLS) % N;

        logic [W-1:0] nbr_r, a_q, r_q, t_q;
        logic         hit;

        assign hit = ld_en && (ld_idx == IDXW'(k));

        mesh_link_mux #(.W(W)) u_mux (
            .dir        (dir_e),
            .from_left  (r_all[LI*W +: W]),
            .from_right (r_all[RI*W +: W]),
            .from_up    (r_all[UI*W +: W]),
            .from_down  (r_all[DI*W +: W]),
            .nbr_r      (nbr_r)
        );

        mesh_pe #(.W(W)) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (step_en),
            .op      (op_e),
            .active  (act_mask[k]),
            .nbr_r   (nbr_r),
            .ld_a    (hit && ld_sel_e == SEL_A),
            .ld_r    (hit && ld_sel_e == SEL_R),
            .ld_t    (hit && ld_sel_e == SEL_T),
            .ld_data (ld_data),
            .a_q     (a_q),
            .r_q     (r_q),
            .t_q     (t_q)
        );

        assign a_all[k*W +: W] = a_q;
        assign r_all[k*W +: W] = r_q;
        assign t_all[k*W +: W] = t_q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_idx == IDXW'(k)) begin
                unique case (rd_sel_e)
                    SEL_A:    rd_data = a_all[k*W +: W];
                    SEL_R:    rd_data = r_all[k*W +: W];
                    SEL_T:    rd_data = t_all[k*W +: W];
                    SEL_NONE: rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mesh_route_checker.sv
module mesh_route_checker #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              step_en,
    input  logic [1:0]                        step_op,
    input  logic [1:0]                        route_dir,
    input  logic [ROWS*COLS-1:0]              act_mask,
    input  logic                              ld_en,
    input  logic [$clog2(ROWS*COLS)-1:0]      ld_idx,
    input  logic [ROWS*COLS*W-1:0]            a_all,
    input  logic [ROWS*COLS*W-1:0]            r_all,
    input  logic [ROWS*COLS*W-1:0]            t_all
);

    localparam int N    = ROWS * COLS;
    localparam int IDXW = $clog2(N);

    assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !ld_en) |=> ($stable(a_all) && $stable(r_all) && $stable(t_all)));

    assert_t_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(t_all));

    for (genvar k = 0; k < N; k++) begin : g_chk
        localparam int LI = (k + N - 1) % N;
        localparam int RI = (k + 1) % N;
        localparam int UI = (k + N - COLS) % N;
        localparam int DI = (k + COLS) % N;

        logic free;
        assign free = !(ld_en && ld_idx == IDXW'(k));

        assert_route_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && step_op == 2'd0 && route_dir == 2'd1 && act_mask[k] && free)
            |=> r_all[k*W +: W] == $past(r_all[RI*W +: W]));

        assert_route_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && step_op == 2'd0 && route_dir == 2'd0 && act_mask[k] && free)
            |=> r_all[k*W +: W] == $past(r_all[LI*W +: W]));

        assert_route_vert_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && step_op == 2'd0 && route_dir[1] && act_mask[k] && free)
            |=> r_all[k*W +: W] == (route_dir == 2'd2 ? $past(r_all[UI*W +: W])
                                                       : $past(r_all[DI*W +: W])));

        assert_inactive_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !act_mask[k] && free)
            |=> ($stable(a_all[k*W +: W]) && $stable(r_all[k*W +: W])));

        assert_cmpx_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && step_op == 2'd1 && act_mask[k] && free)
            |=> r_all[k*W +: W] <= a_all[k*W +: W]);
    end

endmodule

bind mesh_route_fabric mesh_route_checker #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_route_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .step_op   (step_op),
    .route_dir (route_dir),
    .act_mask  (act_mask),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .a_all     (a_all),
    .r_all     (r_all),
    .t_all     (t_all)
);

// File: tb/test_mesh_route_fabric.sv
module test_mesh_route_fabric;

    localparam int ROWS       = 4;
    localparam int COLS       = 8;
    localparam int W          = 8;
    localparam int N          = ROWS * COLS;
    localparam int IDXW       = $clog2(N);
    localparam int CLK_PERIOD = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                step_en = 1'b0;
    logic [1:0]          step_op = '0;
    logic [1:0]          route_dir = '0;
    logic [N-1:0]        act_mask = '0;
    logic                ld_en = 1'b0;
    logic [IDXW-1:0]     ld_idx = '0;
    logic [1:0]          ld_sel = '0;
    logic [W-1:0]        ld_data = '0;
    logic [IDXW-1:0]     rd_idx = '0;
    logic [1:0]          rd_sel = '0;
    logic [W-1:0]        rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [W-1:0] ma [N];
    logic [W-1:0] mr [N];
    logic [W-1:0] mt [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_route_fabric #(.ROWS(ROWS), .COLS(COLS), .W(W)) i_mesh_route_fabric (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .step_op   (step_op),
        .route_dir (route_dir),
        .act_mask  (act_mask),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .rd_idx    (rd_idx),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    // Neighbour source from row/column arithmetic
    function automatic int nbr(int k, int d);
        int row, col;
        row = k / COLS;
        col = k % COLS;
        case (d)
            0: if (col == 0) begin row = (row + ROWS - 1) % ROWS; col = COLS - 1; end
               else col = col - 1;
            1: if (col == COLS - 1) begin row = (row + 1) % ROWS; col = 0; end
               else col = col + 1;
            2: row = (row + ROWS - 1) % ROWS;
            default: row = (row + 1) % ROWS;
        endcase
        return row * COLS + col;
    endfunction

    function automatic logic [N-1:0] rand_mask();
        logic [N-1:0] m;
        for (int b = 0; b < N; b++) m[b] = 1'($urandom);
        return m;
    endfunction

    task automatic check_all(string tag);
        logic [W-1:0] exp_v;
        for (int k = 0; k < N; k++) begin
            for (int s = 0; s < 4; s++) begin
                rd_idx = IDXW'(k);
                rd_sel = 2'(s);
                #1;
                case (s)
                    0: exp_v = ma[k];
                    1: exp_v = mr[k];
                    2: exp_v = mt[k];
                    default: exp_v = '0;
                endcase
                n_checks++;
                if (rd_data !== exp_v) begin
                    n_fails++;
                    $display("FAIL %s elem %0d sel %0d actual %0h expected %0h",
                             tag, k, s, rd_data, exp_v);
                end
            end
        end
    endtask

    // One clock edge with an optional step and an optional load
    task automatic step(bit en, int op, int d, logic [N-1:0] m,
                        bit le, int li, int ls, logic [W-1:0] ldv);
        logic [W-1:0] oa [N];
        logic [W-1:0] orr [N];
        @(negedge clk);
        step_en = en; step_op = 2'(op); route_dir = 2'(d); act_mask = m;
        ld_en = le; ld_idx = IDXW'(li); ld_sel = 2'(ls); ld_data = ldv;
        @(negedge clk);
        step_en = 1'b0; ld_en = 1'b0;
        oa = ma; orr = mr;
        if (en) begin
            for (int k = 0; k < N; k++) begin
                if (m[k]) begin
                    case (op)
                        0: mr[k] = orr[nbr(k, d)];
                        1: if (oa[k] < orr[k]) begin mr[k] = oa[k]; ma[k] = orr[k]; end
                        2: begin mr[k] = oa[k]; ma[k] = orr[k]; end
                        default: ;
                    endcase
                end
            end
        end
        if (le) begin
            case (ls)
                0: ma[li] = ldv;
                1: mr[li] = ldv;
                2: mt[li] = ldv;
                default: ;
            endcase
        end
    endtask

    task automatic load_all_random();
        for (int k = 0; k < N; k++)
            for (int s = 0; s < 3; s++)
                step(1'b0, 0, 0, '0, 1'b1, k, s, W'($urandom));
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        for (int k = 0; k < N; k++) begin ma[k] = '0; mr[k] = '0; mt[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        load_all_random();
        check_all("R2");

        // Directed routes in every direction, full mask covers corners
        step(1'b1, 0, 1, '1, 1'b0, 0, 0, '0); check_all("R3 R6");
        step(1'b1, 0, 0, '1, 1'b0, 0, 0, '0); check_all("R4 R6");
        step(1'b1, 0, 2, '1, 1'b0, 0, 0, '0); check_all("R5 up");
        step(1'b1, 0, 3, '1, 1'b0, 0, 0, '0); check_all("R5 down");
        // Route right from the last element must reach element 0
        step(1'b0, 0, 0, '0, 1'b1, N-1, 1, 8'hA5);
        step(1'b1, 0, 1, '1, 1'b0, 0, 0, '0); check_all("R3 last-to-first");

        // Partial masks
        for (int d = 0; d < 4; d++) begin
            step(1'b1, 0, d, rand_mask(), 1'b0, 0, 0, '0); check_all("R7");
        end

        // Compare-exchange, including a tie
        step(1'b0, 0, 0, '0, 1'b1, 5, 0, 8'h3C);
        step(1'b0, 0, 0, '0, 1'b1, 5, 1, 8'h3C);
        step(1'b1, 1, 0, '1, 1'b0, 0, 0, '0); check_all("R8");
        load_all_random();
        step(1'b1, 1, 0, rand_mask(), 1'b0, 0, 0, '0); check_all("R8 R7");

        // Exchange and idle
        step(1'b1, 2, 0, rand_mask(), 1'b0, 0, 0, '0); check_all("R9 swap");
        step(1'b1, 3, 2, '1, 1'b0, 0, 0, '0);          check_all("R9 idle");

        // step_en low with live-looking controls
        step(1'b0, 0, 1, '1, 1'b0, 0, 0, '0); check_all("R12");
        step(1'b0, 2, 3, '1, 1'b0, 0, 0, '0); check_all("R12");

        // Load colliding with a step on the same element
        step(1'b1, 0, 1, '1, 1'b1, 7, 1, 8'h5A);  check_all("R11 route");
        step(1'b1, 1, 0, '1, 1'b1, 12, 0, 8'h00); check_all("R11 cmpx");
        step(1'b1, 2, 0, '1, 1'b1, 31, 2, 8'hE1); check_all("R11 swap");

        // Constrained random mix
        for (int it = 0; it < 60; it++) begin
            step(1'($urandom), int'($urandom % 4), int'($urandom % 4), rand_mask(),
                 1'($urandom), int'($urandom % N), int'($urandom % 4), W'($urandom));
            check_all("R10 R11 random");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule